// File: doc/BRIEF.md
# Processor Interrupt Acknowledge Port

This block sits between an interrupt distributor and one processor. The distributor holds up its current best candidate: an ID, an 8-bit priority value (lower means more urgent) and, for software-generated IDs, the number of the processor that asked for it. The block compares that priority against a software-programmed threshold. When the candidate passes the threshold, the interface is switched on and no interrupt is already in service, the block raises `irq` to the processor.

Software drives the block through a 32-bit register port with word addresses:

| Word address | Register |
|---|---|
| 0 | Control |
| 1 | Priority threshold |
| 2 | Acknowledge (read only) |
| 3 | Completion (write only) |

A read of the acknowledge register claims the candidate. It returns the ID and marks the interrupt as in service. The distributor is told through a one-cycle `ack_valid` strobe, so that it can clear edge state and stop offering that ID. Writing the claimed value back to the completion register retires the interrupt, and the distributor is told through `eoi_valid`. Nesting of interrupts by priority is not supported: only one interrupt is in service at a time.

The candidate is a level presentation: it is held valid and carries no ready signal, because the block only samples it. The `ack_valid` and `eoi_valid` strobes have no back-pressure. The distributor must take each strobe in the cycle it is high. Register reads return data in `reg_rdata` one cycle after `reg_rd`, and the value is held until the next read. Software must not issue a read and a write in the same cycle.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset, `irq`, `ack_valid` and `eoi_valid` are 0, the control and threshold registers read 0, and an acknowledge read returns 1023.
- R2: `irq` is 1 in the cycle after the one in which all of these hold: the interface is enabled, `cand_valid` is 1, nothing is in service, and `cand_prio` is strictly less than the threshold. In every other case `irq` is 0 in that cycle. A threshold of 0 therefore admits nothing.
- R3: Bit 0 of the control register (word 0) enables the interface. While it is 0, `irq` stays low and an acknowledge read returns 1023 without claiming anything.
- R4: An acknowledge read (word 2) made while the candidate qualifies works as follows. The read returns the ID in bits 9:0. For IDs below 16 it also returns `cand_src` in bits 12:10. All other bits are 0. In the next cycle `ack_valid` is 1 and `ack_id` carries that ID.
- R5: An acknowledge read made while nothing qualifies returns 1023, raises no `ack_valid` and leaves the block's state unchanged.
- R6: `irq` is 0 in the cycle after a claiming read. While an interrupt is in service, `irq` stays 0 and acknowledge reads return 1023.
- R7: A write to the completion register (word 3) whose bits 9:0 equal the in-service ID retires that interrupt. In the next cycle `eoi_valid` is 1 and `eoi_id` carries the ID. `irq` is evaluated again one cycle later.
- R8: A completion write whose ID does not match, or one made while nothing is in service, is ignored. No `eoi_valid` is raised and the in-service state is kept.
- R9: The threshold register (word 1, bits 7:0) reads back as written. `irq` follows the new threshold one cycle after the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| cand_valid | input | 1 | Distributor has a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| cand_src | input | 3 | Requesting processor for IDs below 16 |
| irq | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | One-cycle strobe: an ID was claimed |
| ack_id | output | 10 | ID claimed |
| eoi_valid | output | 1 | One-cycle strobe: an ID was retired |
| eoi_id | output | 10 | ID retired |

## Verification
An acknowledge read and a change of the distributor's candidate can land in the same cycle. The block must claim and return exactly the candidate presented in the read cycle, not the one before it. The bench provokes this by swapping the candidate ID on the same edge that carries the read strobe. It then judges the returned word, `ack_id`, and a later completion that must match the new ID.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_PMR  = 2'd1,
    REG_ACK  = 2'd2,
    REG_EOI  = 2'd3
  } cpuif_reg_e;
endpackage

// File: rtl/cpuif_regs.sv
module cpuif_regs #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [PRIO_W-1:0] wdata,
  output logic              en,
  output logic [PRIO_W-1:0] pmr
);
  import cpuif_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= 1'b0;
      pmr <= '0;
    end else if (wr) begin
      if (addr == REG_CTRL) en  <= wdata[0];
      if (addr == REG_PMR)  pmr <= wdata;
    end
  end
endmodule

// File: rtl/cpuif_gate.sv
module cpuif_gate #(
  parameter int PRIO_W = 8
) (
  input  logic              en,
  input  logic              busy,
  input  logic              cand_valid,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [PRIO_W-1:0] pmr,
  output logic              pass
);
  always_comb pass = en && cand_valid && !busy && (cand_prio < pmr);
endmodule

// File: rtl/cpuif_track.sv
module cpuif_track #(
  parameter int ID_W      = 10,
  parameter int SRC_W     = 3,
  parameter int DATA_W    = 32,
  parameter int SGI_LIMIT = 16,
  parameter int SPUR_ID   = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass,
  input  logic              ack_rd,
  input  logic              eoi_wr,
  input  logic [ID_W-1:0]   eoi_data,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [SRC_W-1:0]  cand_src,
  output logic              busy,
  output logic [DATA_W-1:0] ack_word,
  output logic              ack_valid,
  output logic [ID_W-1:0]   ack_id,
  output logic              eoi_valid,
  output logic [ID_W-1:0]   eoi_id
);
  localparam int SRC_LSB = ID_W;
  localparam logic [ID_W-1:0] SGI_LIM_V = ID_W'(SGI_LIMIT);
  localparam logic [ID_W-1:0] SPUR_V    = ID_W'(SPUR_ID);

  logic [ID_W-1:0] act_id;
  logic            take, retire;

  always_comb begin
    ack_word = '0;
    if (pass) begin
      ack_word[ID_W-1:0] = cand_id;
      if (cand_id < SGI_LIM_V) ack_word[SRC_LSB +: SRC_W] = cand_src;
    end else begin
      ack_word[ID_W-1:0] = SPUR_V;
    end
  end

  assign take   = ack_rd && pass;
  assign retire = eoi_wr && busy && (eoi_data == act_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      act_id    <= '0;
      ack_valid <= 1'b0;
      ack_id    <= '0;
      eoi_valid <= 1'b0;
      eoi_id    <= '0;
    end else begin
      ack_valid <= 1'b0;
      eoi_valid <= 1'b0;
      if (take) begin
        busy      <= 1'b1;
        act_id    <= cand_id;
        ack_valid <= 1'b1;
        ack_id    <= cand_id;
      end else if (retire) begin
        busy      <= 1'b0;
        eoi_valid <= 1'b1;
        eoi_id    <= act_id;
      end
    end
  end

  // R4
  ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> busy);
  // R7
  eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> !busy);
  // R7
  eoi_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> eoi_id == $past(act_id));
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_valid, eoi_valid}));
  // R5
  ack_not_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ack_id != SPUR_V);
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface #(
  parameter int ID_W      = 10,
  parameter int PRIO_W    = 8,
  parameter int SRC_W     = 3,
  parameter int DATA_W    = 32,
  parameter int SGI_LIMIT = 16,
  parameter int SPUR_ID   = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [SRC_W-1:0]  cand_src,
  output logic              irq,
  output logic              ack_valid,
  output logic [ID_W-1:0]   ack_id,
  output logic              eoi_valid,
  output logic [ID_W-1:0]   eoi_id
);
  import cpuif_pkg::*;

  logic              en, busy, pass, ack_rd, eoi_wr;
  logic [PRIO_W-1:0] pmr;
  logic [DATA_W-1:0] ack_word;

  assign ack_rd = reg_rd && (reg_addr == REG_ACK);
  assign eoi_wr = reg_wr && (reg_addr == REG_EOI);

  cpuif_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata[PRIO_W-1:0]), .en(en), .pmr(pmr)
  );

  cpuif_gate #(.PRIO_W(PRIO_W)) u_gate (
    .en(en), .busy(busy), .cand_valid(cand_valid), .cand_prio(cand_prio),
    .pmr(pmr), .pass(pass)
  );

  cpuif_track #(
    .ID_W(ID_W), .SRC_W(SRC_W), .DATA_W(DATA_W),
    .SGI_LIMIT(SGI_LIMIT), .SPUR_ID(SPUR_ID)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .pass(pass), .ack_rd(ack_rd), .eoi_wr(eoi_wr),
    .eoi_data(reg_wdata[ID_W-1:0]), .cand_id(cand_id), .cand_src(cand_src),
    .busy(busy), .ack_word(ack_word), .ack_valid(ack_valid), .ack_id(ack_id),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq <= pass && !ack_rd;
      if (reg_rd) begin
        unique case (reg_addr)
          REG_CTRL: reg_rdata <= DATA_W'(en);
          REG_PMR:  reg_rdata <= DATA_W'(pmr);
          REG_ACK:  reg_rdata <= ack_word;
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  // R2
  irq_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cand_prio) < $past(pmr));
  // R3
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq);
  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !irq);
  // R6
  irq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !irq);
endmodule

// File: tb/tb_cpu_irq_iface.sv
module tb_cpu_irq_iface;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic [2:0]  cand_src = '0;
  logic        irq, ack_valid, eoi_valid;
  logic [9:0]  ack_id, eoi_id;

  int checks = 0, errors = 0;
  logic [31:0] rv;
  logic        seen_ack, seen_eoi;
  logic [9:0]  seen_ack_id, seen_eoi_id;

  always #4 clk = ~clk;

  cpu_irq_iface dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
    .cand_src(cand_src), .irq(irq), .ack_valid(ack_valid), .ack_id(ack_id),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    seen_eoi = eoi_valid; seen_eoi_id = eoi_id;
    seen_ack = ack_valid;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
    seen_ack = ack_valid; seen_ack_id = ack_id;
    seen_eoi = eoi_valid;
  endtask

  function automatic logic [31:0] exp_ack(input logic [9:0] id, input logic [2:0] src);
    return (id < 10'd16) ? ({29'd0, src} << 10) | 32'(id) : 32'(id);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 ack_valid", 32'(ack_valid), 0);
    rd(2'd0, rv); check("R1 ctrl", rv, 0);
    rd(2'd1, rv); check("R1 pmr", rv, 0);
    rd(2'd2, rv); check("R1 ack spurious", rv, 1023);
    check("R1 no ack strobe", 32'(seen_ack), 0);

    // R2 mask 0 admits nothing
    wr(2'd0, 32'd1);
    cand_valid = 1'b1; cand_id = 10'd40; cand_prio = 8'h00;
    @(negedge clk);
    check("R2 mask zero", 32'(irq), 0);

    // R2 / R9 sweep of threshold against priority
    for (int m = 0; m < 256; m += 15) begin
      wr(2'd1, 32'(m));
      rd(2'd1, rv); check("R9 pmr readback", rv, 32'(m));
      for (int p = 0; p < 256; p += 17) begin
        cand_prio = 8'(p);
        @(negedge clk);
        check("R2 compare", 32'(irq), 32'(p < m));
      end
    end
    wr(2'd1, 32'h80);
    cand_prio = 8'h7F; @(negedge clk); check("R2 just below", 32'(irq), 1);
    cand_prio = 8'h80; @(negedge clk); check("R2 equal", 32'(irq), 0);

    // R9 threshold change retimes irq
    cand_prio = 8'h40; wr(2'd1, 32'h41); @(negedge clk);
    check("R9 admitted", 32'(irq), 1);
    wr(2'd1, 32'h40);
    check("R9 old mask still", 32'(irq), 1);
    @(negedge clk);
    check("R9 new mask", 32'(irq), 0);

    // R3 enable
    wr(2'd1, 32'hF0); cand_prio = 8'h10; @(negedge clk);
    check("R3 on", 32'(irq), 1);
    wr(2'd0, 32'd0); @(negedge clk);
    check("R3 off irq", 32'(irq), 0);
    rd(2'd2, rv); check("R3 off ack", rv, 1023);
    check("R3 off no strobe", 32'(seen_ack), 0);
    rd(2'd0, rv); check("R3 ctrl read", rv, 0);
    wr(2'd0, 32'd1); @(negedge clk);
    check("R3 back on", 32'(irq), 1);

    // R4 / R6 / R7 over ID classes
    for (int k = 0; k < 22; k++) begin
      logic [9:0] id;
      logic [2:0] src;
      id = (k < 16) ? 10'(k) : (k == 16) ? 10'd16 : (k == 17) ? 10'd31 :
           (k == 18) ? 10'd32 : (k == 19) ? 10'd100 : (k == 20) ? 10'd500 : 10'd1019;
      src = 3'(k * 3 + 1);
      cand_id = id; cand_src = src; cand_prio = 8'h10;
      @(negedge clk);
      check("R2 candidate up", 32'(irq), 1);
      rd(2'd2, rv);
      check("R4 ack word", rv, exp_ack(id, src));
      check("R4 ack strobe", 32'(seen_ack), 1);
      check("R4 ack id", 32'(seen_ack_id), 32'(id));
      check("R6 irq drops", 32'(irq), 0);
      rd(2'd2, rv); check("R6 busy spurious", rv, 1023);
      check("R6 irq held low", 32'(irq), 0);
      wr(2'd3, exp_ack(id, src));
      check("R7 eoi strobe", 32'(seen_eoi), 1);
      check("R7 eoi id", 32'(seen_eoi_id), 32'(id));
      @(negedge clk);
      check("R7 irq again", 32'(irq), 1);
    end

    // R8 mismatched and idle completion
    cand_id = 10'd50;
    rd(2'd2, rv); check("R4 ack 50", rv, 50);
    wr(2'd3, 32'd51);
    check("R8 mismatch no strobe", 32'(seen_eoi), 0);
    @(negedge clk); @(negedge clk);
    check("R8 still busy irq", 32'(irq), 0);
    rd(2'd2, rv); check("R8 still busy ack", rv, 1023);
    wr(2'd3, 32'd50);
    check("R8 real eoi", 32'(seen_eoi), 1);
    wr(2'd3, 32'd50);
    check("R8 idle eoi ignored", 32'(seen_eoi), 0);
    rd(2'd2, rv); check("R8 state kept", rv, 50);
    wr(2'd3, 32'd50);

    // R5 nothing qualifies
    cand_valid = 1'b0; @(negedge clk); @(negedge clk);
    check("R5 irq low", 32'(irq), 0);
    rd(2'd2, rv); check("R5 spurious", rv, 1023);
    check("R5 no strobe", 32'(seen_ack), 0);
    cand_valid = 1'b1; @(negedge clk);
    check("R5 unchanged", 32'(irq), 1);

    // R4 candidate swap in the read cycle
    cand_id = 10'd60; @(negedge clk);
    reg_rd = 1'b1; reg_addr = 2'd2; cand_id = 10'd77;
    @(negedge clk);
    reg_rd = 1'b0; cand_id = 10'd60;
    check("R4 swap word", reg_rdata, 77);
    check("R4 swap id", 32'(ack_id), 77);
    wr(2'd3, 32'd60); check("R8 swap old id", 32'(seen_eoi), 0);
    wr(2'd3, 32'd77); check("R7 swap retire", 32'(seen_eoi_id), 77);

    finish_run();
  end
endmodule